// File: doc/BRIEF.md
# Strobe-Driven Serial Buffer Readout

This block lets a small host controller pull stored card-track bits out of a chip over two wires. It owns one output line, `data_o`, which rests high, and one input, `strobe_n`, which the host pulses low. While a capture is under way, a decoder writes track bits into three equal track buffers through a plain write port. When the decoder reports end of card, the block pulls `data_o` low. The host then gives two handshake pulses, and after that it clocks the stored data out one bit per strobe.

The handshake has two forms. After a clean end of card (the zero-run flag), the first pulse releases `data_o` high again. The second pulse freezes the buffers, and after a settling delay the block acknowledges by pulling `data_o` low. After the fallback end-of-card flag (timeout), both pulses are still needed, but `data_o` stays low and gives no acknowledgement.

Extraction then proceeds as follows:
- A fixed 16-bit revision word comes out once, most significant bit first.
- The pointer walks forward through tracks A, B, C in arrival order.
- It then walks backward through C, B, A.
- This round trip repeats a fixed number of times.
- After the last round trip, `data_o` stays high until reset.

The strobe input is synchronised with two flops, and only its falling edges count.

Top module: `strobe_readout`

## Requirements
- R1: After reset, and while no end-of-card flag has been raised, `data_o` is high, and strobe pulses have no effect on it.
- R2: A pulse on `flag_zeroes` drives `data_o` low on the next clock. The first later falling edge of `strobe_n` returns `data_o` high.
- R3: Only a high-to-low transition of `strobe_n` counts as a handshake pulse. If `strobe_n` is already low when the flag appears, holding it low or raising it changes nothing.
- R4: In the zero-run case, `data_o` goes low exactly `SETTLE_CYC` clocks after the second handshake edge is detected. Until then it stays high.
- R5: A pulse on `flag_aux` (with `flag_zeroes` low) drives `data_o` low. It stays low through both handshake pulses, and there is no settling delay.
- R6: The first `PRE_BITS` extraction strobes present `PREAMBLE`, most significant bit first. A one bit is shown as `data_o` low and a zero bit as `data_o` high. This polarity holds for every extracted bit.
- R7: Bit i of track t (t = 0 for A, 1 for B, 2 for C) sits at linear position t*TRACK_BITS+i. Forward passes present positions 0 up to 3*TRACK_BITS-1 in order.
- R8: Each backward pass presents positions from 3*TRACK_BITS-1 down to 0. The last position is therefore presented twice at the turn, and position 0 is presented twice between round trips.
- R9: Exactly `TRIPS` forward-and-back passes are presented. Every later strobe leaves `data_o` high until reset.
- R10: Track writes take effect only before the second handshake pulse. Writes made after it leave the buffered data unchanged.
- R11: A reset during extraction returns `data_o` high. The next capture again starts with the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_n | input | 1 | Host strobe, asynchronous, active on its falling edge |
| flag_zeroes | input | 1 | Clean end-of-card indication from the decoder |
| flag_aux | input | 1 | Fallback (timeout) end-of-card indication from the decoder |
| wr_en | input | 1 | Track bit write strobe |
| wr_track | input | $clog2(NUM_TRACKS) | Track select for the write, 0 = A |
| wr_idx | input | $clog2(TRACK_BITS) | Bit index inside the track, in arrival order |
| wr_bit | input | 1 | Bit value to store |
| data_o | output | 1 | Serial line to host: rests high, low means a one bit during extraction |

## Verification
The assertions assume four things about the inputs:
- Both end-of-card flags are single-clock pulses that arrive only while the block is collecting.
- Track writes address valid positions.
- `strobe_n` stays at each level long enough to pass the two synchroniser flops.
- Only one edge is detected per host pulse.

The stimulus keeps within these limits. It holds each strobe level for several clocks, raises each flag for exactly one clock, writes only inside the track ranges, and issues the second handshake pulse only after the host has seen the cleared level.

// File: rtl/strobe_readout_pkg.sv
package strobe_readout_pkg;

  typedef enum logic [2:0] {
    HS_COLLECT   = 3'd0,
    HS_WAIT_CLR  = 3'd1,
    HS_WAIT_STOP = 3'd2,
    HS_SETTLE    = 3'd3,
    HS_SHIFT     = 3'd4
  } hs_state_e;

  typedef enum logic [1:0] {
    PH_PRE = 2'd0,
    PH_FWD = 2'd1,
    PH_BWD = 2'd2,
    PH_END = 2'd3
  } phase_e;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n_i,
  output logic fall_o
);

  logic meta_q;
  logic sync_q;
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      last_q <= 1'b1;
    end else begin
      meta_q <= strobe_n_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign fall_o = last_q & ~sync_q;

  // R3: an edge is reported for one cycle only
  a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/track_store.sv
module track_store #(
  parameter int TRACK_BITS = 608,
  parameter int NUM_TRACKS = 3,
  localparam int DEPTH = TRACK_BITS * NUM_TRACKS,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TW    = (NUM_TRACKS > 1) ? $clog2(NUM_TRACKS) : 1,
  localparam int XW    = (TRACK_BITS > 1) ? $clog2(TRACK_BITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_allow,
  input  logic [TW-1:0] wr_track,
  input  logic [XW-1:0] wr_idx,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);

  logic [DEPTH-1:0] mem;
  logic [AW:0]      waddr_full;
  logic             in_range;
  logic             wr_fire;

  assign waddr_full = (AW+1)'(wr_track) * (AW+1)'(TRACK_BITS) + (AW+1)'(wr_idx);
  assign in_range   = (32'(wr_track) < NUM_TRACKS) && (32'(wr_idx) < TRACK_BITS);
  assign wr_fire    = wr_en & wr_allow & in_range;

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem[waddr_full[AW-1:0]] <= wr_bit;
    end
  end

  assign rd_bit = mem[rd_addr];

  // R10: once collection has stopped, a write leaves the array untouched
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_allow) |=> (mem === $past(mem)));

endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import strobe_readout_pkg::*;
#(
  parameter int DEPTH    = 1824,
  parameter int PRE_BITS = 16,
  parameter int TRIPS    = 4,
  localparam int MAXV    = (DEPTH > PRE_BITS) ? DEPTH : PRE_BITS,
  localparam int IW      = (MAXV > 1) ? $clog2(MAXV) : 1,
  localparam int CW      = (TRIPS > 1) ? $clog2(TRIPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output phase_e        phase_o,
  output logic [IW-1:0] idx_o
);

  phase_e        phase_q, phase_d;
  logic [IW-1:0] idx_q,   idx_d;
  logic [CW-1:0] trip_q,  trip_d;

  localparam logic [IW-1:0] PRE_LAST  = IW'(PRE_BITS - 1);
  localparam logic [IW-1:0] DATA_LAST = IW'(DEPTH - 1);
  localparam logic [CW-1:0] TRIP_LAST = CW'(TRIPS - 1);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    trip_d  = trip_q;
    if (step) begin
      unique case (phase_q)
        PH_PRE: begin
          if (idx_q == PRE_LAST) begin
            phase_d = PH_FWD;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        PH_FWD: begin
          if (idx_q == DATA_LAST) begin
            phase_d = PH_BWD;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        PH_BWD: begin
          if (idx_q == '0) begin
            if (trip_q == TRIP_LAST) begin
              phase_d = PH_END;
            end else begin
              phase_d = PH_FWD;
              trip_d  = trip_q + 1'b1;
            end
          end else begin
            idx_d = idx_q - 1'b1;
          end
        end
        default: begin
          phase_d = PH_END;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PRE;
      idx_q   <= '0;
      trip_q  <= '0;
    end else if (step) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      trip_q  <= trip_d;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;

  // R7 R8: the pointer stays inside the buffer during data passes
  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_PRE) |-> (32'(idx_q) < DEPTH));
  // R6: preamble index stays below its length
  a_r6_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PRE) |-> (32'(idx_q) < PRE_BITS));
  // R9: the trip counter never exceeds the configured count
  a_r9_trip_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(trip_q) < TRIPS);
  // R9: the end phase is sticky
  a_r9_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_END) |=> (phase_q == PH_END));
  // R8: a backward pass that reaches position 0 either finishes or turns forward
  a_r8_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase_q == PH_BWD && idx_q == '0) |=> (phase_q == PH_FWD || phase_q == PH_END));

endmodule

// File: rtl/strobe_readout.sv
module strobe_readout
  import strobe_readout_pkg::*;
#(
  parameter int                    TRACK_BITS = 608,
  parameter int                    NUM_TRACKS = 3,
  parameter int                    PRE_BITS   = 16,
  parameter logic [PRE_BITS-1:0]   PREAMBLE   = 16'hA5C3,
  parameter int                    TRIPS      = 4,
  parameter int                    SETTLE_CYC = 64
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            strobe_n,
  input  logic                                            flag_zeroes,
  input  logic                                            flag_aux,
  input  logic                                            wr_en,
  input  logic [((NUM_TRACKS > 1) ? $clog2(NUM_TRACKS) : 1)-1:0] wr_track,
  input  logic [((TRACK_BITS > 1) ? $clog2(TRACK_BITS) : 1)-1:0] wr_idx,
  input  logic                                            wr_bit,
  output logic                                            data_o
);

  localparam int DEPTH = TRACK_BITS * NUM_TRACKS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MAXV  = (DEPTH > PRE_BITS) ? DEPTH : PRE_BITS;
  localparam int IW    = (MAXV > 1) ? $clog2(MAXV) : 1;
  localparam int SW    = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

  // reset: asserted asynchronously, released after two clocks
  logic rst_meta_q;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic strobe_fall;

  strobe_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_q),
    .strobe_n_i (strobe_n),
    .fall_o     (strobe_fall)
  );

  hs_state_e     state_q, state_d;
  logic          aux_q, aux_d;
  logic [SW-1:0] settle_q, settle_d;
  logic          data_q, data_d;
  logic          wr_allow;
  logic          seq_step;
  phase_e        seq_phase;
  logic [IW-1:0] seq_idx;
  logic          rd_bit;
  logic          cur_bit;
  int            pre_sel;

  readout_seq #(
    .DEPTH    (DEPTH),
    .PRE_BITS (PRE_BITS),
    .TRIPS    (TRIPS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_q),
    .step    (seq_step),
    .phase_o (seq_phase),
    .idx_o   (seq_idx)
  );

  track_store #(
    .TRACK_BITS (TRACK_BITS),
    .NUM_TRACKS (NUM_TRACKS)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (wr_en),
    .wr_allow (wr_allow),
    .wr_track (wr_track),
    .wr_idx   (wr_idx),
    .wr_bit   (wr_bit),
    .rd_addr  (AW'(seq_idx)),
    .rd_bit   (rd_bit)
  );

  assign pre_sel  = PRE_BITS - 1 - int'(seq_idx);
  assign cur_bit  = (seq_phase == PH_PRE) ? PREAMBLE[pre_sel] : rd_bit;
  assign wr_allow = (state_q == HS_COLLECT) || (state_q == HS_WAIT_CLR) ||
                    (state_q == HS_WAIT_STOP);
  assign seq_step = (state_q == HS_SHIFT) && strobe_fall;

  // next state
  always_comb begin
    state_d  = state_q;
    aux_d    = aux_q;
    settle_d = settle_q;
    data_d   = data_q;
    unique case (state_q)
      HS_COLLECT: begin
        data_d = 1'b1;
        if (flag_zeroes) begin
          state_d = HS_WAIT_CLR;
          aux_d   = 1'b0;
          data_d  = 1'b0;
        end else if (flag_aux) begin
          state_d = HS_WAIT_CLR;
          aux_d   = 1'b1;
          data_d  = 1'b0;
        end
      end
      HS_WAIT_CLR: begin
        if (strobe_fall) begin
          state_d = HS_WAIT_STOP;
          data_d  = ~aux_q;
        end
      end
      HS_WAIT_STOP: begin
        if (strobe_fall) begin
          settle_d = '0;
          if (aux_q) begin
            state_d = HS_SHIFT;
            data_d  = 1'b0;
          end else begin
            state_d = HS_SETTLE;
            data_d  = 1'b1;
          end
        end
      end
      HS_SETTLE: begin
        if (settle_q == SETTLE_LAST) begin
          state_d = HS_SHIFT;
          data_d  = 1'b0;
        end else begin
          settle_d = settle_q + 1'b1;
        end
      end
      HS_SHIFT: begin
        if (strobe_fall) begin
          data_d = (seq_phase == PH_END) ? 1'b1 : ~cur_bit;
        end
      end
      default: begin
        state_d = HS_COLLECT;
        data_d  = 1'b1;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q  <= HS_COLLECT;
      aux_q    <= 1'b0;
      settle_q <= '0;
      data_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      aux_q    <= aux_d;
      settle_q <= settle_d;
      data_q   <= data_d;
    end
  end

  assign data_o = data_q;

  // R1: line rests high while collecting with no flag
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == HS_COLLECT && !flag_zeroes && !flag_aux) |=> data_o);
  // R2: a flag while collecting pulls the line low
  a_r2_flag_low: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == HS_COLLECT && (flag_zeroes || flag_aux)) |=> !data_o);
  // R3: without a detected edge the handshake does not advance
  a_r3_hold_clr: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == HS_WAIT_CLR && !strobe_fall) |=> (state_q == HS_WAIT_CLR));
  // R4: the settling phase lasts the configured count
  a_r4_settle_len: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == HS_SHIFT && $past(state_q) == HS_SETTLE) |-> ($past(settle_q) == SETTLE_LAST));
  // R4 R5: entering extraction is acknowledged with a low line
  a_r4_ack_low: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == HS_SHIFT && $past(state_q) != HS_SHIFT) |-> !data_o);
  // R5: fallback handshake gives no acknowledgement on the line
  a_r5_aux_silent: assert property (@(posedge clk) disable iff (!rst_q)
    (aux_q && (state_q == HS_WAIT_CLR || state_q == HS_WAIT_STOP)) |-> !data_o);
  // R9: strobes after the final pass keep the line high
  a_r9_end_high: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == HS_SHIFT && seq_phase == PH_END && strobe_fall) |=> data_o);
  // R11: extraction only begins through the handshake
  a_r11_no_skip: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == HS_COLLECT) |=> (state_q == HS_COLLECT || state_q == HS_WAIT_CLR));

endmodule

// File: tb/tb_strobe_readout.sv
module tb_strobe_readout;

  localparam int          CLK_PERIOD = 10;
  localparam int          TRACK_BITS = 16;
  localparam int          NUM_TRACKS = 3;
  localparam int          DEPTH      = TRACK_BITS * NUM_TRACKS;
  localparam int          PRE_BITS   = 16;
  localparam logic [15:0] PRE_WORD   = 16'hA5C3;
  localparam int          TRIPS      = 4;
  localparam int          SETTLE     = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe_n;
  logic       flag_zeroes;
  logic       flag_aux;
  logic       wr_en;
  logic [1:0] wr_track;
  logic [3:0] wr_idx;
  logic       wr_bit;
  logic       data_o;

  int checks = 0;
  int errors = 0;

  logic  model [DEPTH];
  logic  exp_q [$];
  string tag_q [$];
  event  sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_readout #(
    .TRACK_BITS (TRACK_BITS),
    .NUM_TRACKS (NUM_TRACKS),
    .PRE_BITS   (PRE_BITS),
    .PREAMBLE   (PRE_WORD),
    .TRIPS      (TRIPS),
    .SETTLE_CYC (SETTLE)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_n    (strobe_n),
    .flag_zeroes (flag_zeroes),
    .flag_aux    (flag_aux),
    .wr_en       (wr_en),
    .wr_track    (wr_track),
    .wr_idx      (wr_idx),
    .wr_bit      (wr_bit),
    .data_o      (data_o)
  );

  function automatic logic pattern(int i);
    return logic'(((i * 5 + 1) % 7) < 3);
  endfunction

  task automatic check(logic exp, string tag);
    checks++;
    if (data_o !== exp) begin
      errors++;
      $display("FAIL %s: data_o=%b expected %b at %0t", tag, data_o, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_bit(int t, int i, logic b);
    wr_en    = 1'b1;
    wr_track = 2'(t);
    wr_idx   = 4'(i);
    wr_bit   = b;
    wait_n(1);
    wr_en    = 1'b0;
  endtask

  // driver: one extraction strobe with its expected line level
  task automatic strobe_bit(logic exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    strobe_n = 1'b0;
    wait_n(5);
    -> sample_ev;
    wait_n(1);
    strobe_n = 1'b1;
    wait_n(2);
  endtask

  // monitor: compare the line against the scoreboard head
  always @(sample_ev) begin
    logic  e;
    string t;
    if (exp_q.size() == 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: sample with empty queue, data_o=%b expected none", data_o);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(e, t);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, data_o=%b expected completion", data_o);
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    strobe_n    = 1'b1;
    flag_zeroes = 1'b0;
    flag_aux    = 1'b0;
    wr_en       = 1'b0;
    wr_track    = '0;
    wr_idx      = '0;
    wr_bit      = 1'b0;
    rst_n       = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    check(1'b1, "R1 reset level");

    // fill the three tracks
    for (int t = 0; t < NUM_TRACKS; t++) begin
      for (int i = 0; i < TRACK_BITS; i++) begin
        model[t*TRACK_BITS + i] = pattern(t*TRACK_BITS + i);
        write_bit(t, i, model[t*TRACK_BITS + i]);
      end
    end
    check(1'b1, "R1 level after writes");
    strobe_n = 1'b0; wait_n(5); check(1'b1, "R1 strobe while collecting");
    strobe_n = 1'b1; wait_n(5); check(1'b1, "R1 strobe release while collecting");

    // zero-run end flag with strobe already held low
    strobe_n = 1'b0;
    wait_n(4);
    flag_zeroes = 1'b1;
    wait_n(1);
    flag_zeroes = 1'b0;
    wait_n(1);
    check(1'b0, "R2 flag drives low");
    wait_n(5);
    check(1'b0, "R3 held-low strobe ignored");
    strobe_n = 1'b1;
    wait_n(5);
    check(1'b0, "R3 rising strobe ignored");
    strobe_n = 1'b0;
    wait_n(5);
    check(1'b1, "R2 first pulse clears");
    strobe_n = 1'b1;
    wait_n(3);

    // write still accepted before stop
    model[3] = ~model[3];
    write_bit(0, 3, model[3]);
    check(1'b1, "R10 write before stop keeps line");

    // stop pulse and settling delay
    strobe_n = 1'b0;
    wait_n(SETTLE + 2);
    check(1'b1, "R4 still high during settle");
    wait_n(1);
    check(1'b0, "R4 acknowledged after settle");
    strobe_n = 1'b1;
    wait_n(3);

    // write after stop must be ignored (model unchanged)
    write_bit(1, 2, ~model[TRACK_BITS + 2]);
    wait_n(2);

    for (int k = 0; k < PRE_BITS; k++) strobe_bit(~PRE_WORD[PRE_BITS-1-k], "R6 preamble bit");
    for (int r = 0; r < TRIPS; r++) begin
      for (int a = 0; a < DEPTH; a++) begin
        if (a == TRACK_BITS + 2) strobe_bit(~model[a], "R10 frozen position forward");
        else                     strobe_bit(~model[a], "R7 forward pass");
      end
      for (int a = DEPTH - 1; a >= 0; a--) strobe_bit(~model[a], "R8 backward pass");
    end
    for (int k = 0; k < 3; k++) strobe_bit(1'b1, "R9 after last trip");
    wait_n(2);
    check(1'b1, "R9 idle level after end");

    // second capture with the fallback flag
    do_reset();
    check(1'b1, "R11 reset returns high");
    flag_aux = 1'b1;
    wait_n(1);
    flag_aux = 1'b0;
    wait_n(1);
    check(1'b0, "R5 aux flag drives low");
    strobe_n = 1'b0; wait_n(5); check(1'b0, "R5 no ack on first pulse");
    strobe_n = 1'b1; wait_n(3); check(1'b0, "R5 low between pulses");
    strobe_n = 1'b0; wait_n(4); check(1'b0, "R5 low after second pulse");
    strobe_n = 1'b1; wait_n(3);
    for (int k = 0; k < 6; k++) strobe_bit(~PRE_WORD[PRE_BITS-1-k], "R11 preamble again");

    // reset in the middle of extraction
    do_reset();
    check(1'b1, "R11 reset mid extraction");
    strobe_n = 1'b0; wait_n(5); check(1'b1, "R1 strobe after reset ignored");
    strobe_n = 1'b1; wait_n(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule